// File: doc/BRIEF.md
# Header-Addressed SPI Register Port

This block is the serial configuration port of a radio-style device. An external controller selects it with an active-low chip select and clocks bytes in SPI mode 0 (SI sampled on the rising edge of SCLK, SO changed on the falling edge), most significant bit first. Every transaction opens with one header byte that names the direction, the burst choice and a 6-bit address. While that header comes in, the block shifts out a status byte that carries a ready flag and the current radio state.

Header addresses pick one of four kinds of access. The low range reaches a 47-entry register file directly. One escape address takes a second byte as an index into a 256-entry extended register file. A range of single-byte strobe codes is passed to the rest of the device as one-cycle command pulses. Two window addresses stream bytes to or from queues outside the block. All SPI pins are brought into the system clock domain by synchronizers, so SCLK has to be well below the system clock.

Top module: `spi_hdr_regif`

## Requirements
- R1: Every byte is shifted most significant bit first on both spiSi and spiSo. spiSi is sampled on rising spiSclk and spiSo changes after falling spiSclk.
- R2: Header bit 7 selects read (1) or write (0) and bit 6 selects burst (1). Bits 5:0 give the address. During the header the block returns the status byte {~chipReady, radioState[2:0], 4'b0000}. Its top bit is on spiSo before the first rising spiSclk after spiCsN falls, so spiSo is low when the device is ready.
- R3: A non-burst access to an address 0x00 to 0x2E moves exactly one data byte, a write or a read of that register. The byte after it is treated as a new header within the same selection.
- R4: In burst mode the register address advances by one after each data byte until spiCsN rises. In the normal space it wraps from 0x2E to 0x00.
- R5: Header address 0x2F takes the next byte as an index into a 256-entry extended space, followed by data bytes. Single and burst access work as in R3 and R4, and a burst index wraps from 0xFF to 0x00.
- R6: Header addresses 0x30 to 0x3D, with any direction or burst bit, have no data phase. Each produces one cmdValid pulse with cmdCode equal to the address, and the next byte is a header.
- R7: Header addresses 0x3E and 0x3F open a queue window, with fifoPort equal to the address bit 0. A write window gives one fifoPush pulse per completed byte, carrying that byte. A read window sends fifoRdData and gives one fifoPop pulse per completed byte. A partial byte or a trailing clock edge pops nothing.
- R8: If chipReady is low when spiCsN falls, spiSo starts high and every byte of that selection is ignored. No register changes and no pulse is produced.
- R9: While spiCsN is high, spiSoEn is low. If spiCsN rises in the middle of a byte, that byte is dropped and the next selection starts with a header.
- R10: While write data bytes or an extended index byte are received, spiSo returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock from the controller, idle low |
| spiCsN | input | 1 | Active-low select |
| spiSi | input | 1 | Serial data into the block |
| spiSo | output | 1 | Serial data out of the block |
| spiSoEn | output | 1 | Output enable for the spiSo pad driver |
| chipReady | input | 1 | Device ready. Reported inverted as status bit 7 |
| radioState | input | 3 | Radio state code reported in status bits 6:4 |
| cmdValid | output | 1 | One-cycle strobe command pulse |
| cmdCode | output | 6 | Strobe address that goes with cmdValid |
| fifoPort | output | 1 | Which queue window is open (header address bit 0) |
| fifoPush | output | 1 | One-cycle pulse: fifoWrData is to be queued |
| fifoWrData | output | 8 | Byte received in a write window |
| fifoPop | output | 1 | One-cycle pulse: the head of the read queue has been sent |
| fifoRdData | input | 8 | Head of the read queue, held until fifoPop |

## Verification
The bench goes after the address wraps. It bursts across 0x2E in the normal space and across 0xFF in the extended space. A counter that ran past 0x2E would write into the escape slot or lose the byte, and a narrow extended counter would wrap early. It checks that a read window pops exactly once per byte sent, so a design that fetched ahead would use up an extra queue entry, and that a strobe header between accesses is taken as a header rather than as data. It drops spiCsN in the middle of a write byte and selects the block while it is not ready. A design that committed partial bytes or ignored readiness would change a register that must keep its value.

// File: rtl/spi_hdr_pkg.sv
package spi_hdr_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NORM_COUNT = 47;
  localparam int unsigned NORM_AW    = 6;
  localparam int unsigned EXT_AW     = 8;
  localparam int unsigned EXT_DEPTH  = 1 << EXT_AW;

  // header address map; these boundaries decide the decode
  localparam logic [5:0] LAST_NORM = 6'h2E;
  localparam logic [5:0] EXT_ESC   = 6'h2F;
  localparam logic [5:0] STROBE_LO = 6'h30;
  localparam logic [5:0] STROBE_HI = 6'h3D;

  typedef enum logic [1:0] {
    TX_STATUS = 2'd0,
    TX_REG    = 2'd1,
    TX_FIFO   = 2'd2
  } txSrc_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic              txLoad;
    txSrc_e            txSrc;
    logic              rdExt;
    logic [EXT_AW-1:0] rdIdx;
    logic              wrEn;
    logic              wrExt;
    logic [EXT_AW-1:0] wrIdx;
  } ctlCmd_t;

  function automatic logic [BYTE_W-1:0] statusByte(input logic ready, input logic [2:0] st);
    return {~ready, st, 4'b0000};
  endfunction
endpackage

// File: rtl/spi_hdr_dp.sv
module spi_hdr_dp
  import spi_hdr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              spiSi,
  input  logic              chipReady,
  input  logic [2:0]        radioState,
  input  ctlCmd_t           cmd,
  input  logic [BYTE_W-1:0] fifoRdData,
  output logic              spiSo,
  output logic              spiSoEn,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              csIdle,
  output logic              blocked
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [EXT_AW-1:0] NORM_LIMIT = EXT_AW'(NORM_COUNT);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, siSync;
  logic sclkPrev, csPrev;
  logic sclkS, siS, csLow, selected, csFall, sclkRise, sclkFall;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift, txNext, rdData, curStatus;
  logic txFifo;
  logic [BYTE_W-1:0] normRegs [NORM_COUNT];
  logic [BYTE_W-1:0] extRegs  [EXT_DEPTH];

  // pin synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      siSync   <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      siSync   <= {siSync[SYNC_STAGES-2:0], spiSi};
    end
  end

  assign sclkS     = sclkSync[SYNC_STAGES-1];
  assign siS       = siSync[SYNC_STAGES-1];
  assign csLow     = ~csSync[SYNC_STAGES-1];
  assign selected  = csLow & ~csPrev;
  assign csFall    = csLow & csPrev;
  assign sclkRise  = sclkS & ~sclkPrev;
  assign sclkFall  = ~sclkS & sclkPrev;
  assign curStatus = statusByte(chipReady, radioState);

  always_comb begin
    if (cmd.rdExt)                rdData = extRegs[cmd.rdIdx];
    else if (cmd.rdIdx < NORM_LIMIT) rdData = normRegs[cmd.rdIdx[NORM_AW-1:0]];
    else                          rdData = '0;
  end

  // shift engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      txNext   <= '0;
      txFifo   <= 1'b0;
      byteDone <= 1'b0;
      blocked  <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= ~csLow;
      byteDone <= 1'b0;
      if (csFall) begin
        bitCnt  <= '0;
        txShift <= curStatus;
        txFifo  <= 1'b0;
        blocked <= ~chipReady;
      end else if (!selected) begin
        bitCnt <= '0;
      end else begin
        if (sclkRise) begin
          rxShift <= {rxShift[BYTE_W-2:0], siS};
          bitCnt  <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) byteDone <= 1'b1;
        end
        if (sclkFall) begin
          if (bitCnt == '0) txShift <= txFifo ? fifoRdData : txNext;
          else              txShift <= {txShift[BYTE_W-2:0], 1'b0};
        end
        if (cmd.txLoad) begin
          txFifo <= (cmd.txSrc == TX_FIFO);
          txNext <= (cmd.txSrc == TX_REG) ? rdData : curStatus;
        end
      end
    end
  end

  // register files
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NORM_COUNT; i++) normRegs[i] <= '0;
    end else if (cmd.wrEn && !cmd.wrExt && cmd.wrIdx < NORM_LIMIT) begin
      normRegs[cmd.wrIdx[NORM_AW-1:0]] <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < EXT_DEPTH; i++) extRegs[i] <= '0;
    end else if (cmd.wrEn && cmd.wrExt) begin
      extRegs[cmd.wrIdx] <= rxShift;
    end
  end

  assign rxByte  = rxShift;
  assign csIdle  = csPrev;
  assign spiSoEn = ~csPrev;
  assign spiSo   = spiSoEn ? txShift[BYTE_W-1] : 1'b0;

  assert_status_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> (spiSoEn && spiSo == ~$past(chipReady)));

  assert_write_whole_byte_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |-> (byteDone && !csIdle));

  assert_count_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    (csIdle && !csLow) |=> bitCnt == '0);
endmodule

// File: rtl/spi_hdr_ctl.sv
module spi_hdr_ctl
  import spi_hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              csIdle,
  input  logic              blocked,
  output ctlCmd_t           cmd,
  output logic              cmdValid,
  output logic [5:0]        cmdCode,
  output logic              fifoPort,
  output logic              fifoPush,
  output logic [BYTE_W-1:0] fifoWrData,
  output logic              fifoPop
);
  typedef enum logic [1:0] {S_HDR, S_EXTA, S_DATA, S_FIFO} state_e;

  state_e state, stateN;
  logic [EXT_AW-1:0] addr, addrN, nextAddr;
  logic isRead, isReadN, isBurst, isBurstN, isExt, isExtN, portN;
  logic act, strobeHit, pushHit, popHit;
  logic hdrRw, hdrBurst;
  logic [5:0] hdrAddr;

  assign act      = byteDone & ~blocked & ~csIdle;
  assign hdrRw    = rxByte[7];
  assign hdrBurst = rxByte[6];
  assign hdrAddr  = rxByte[5:0];

  always_comb begin
    if (isExt)                              nextAddr = addr + 1'b1;
    else if (addr == EXT_AW'(LAST_NORM))    nextAddr = '0;
    else                                    nextAddr = addr + 1'b1;
  end

  always_comb begin
    cmd       = '0;
    cmd.txSrc = TX_STATUS;
    stateN    = state;
    addrN     = addr;
    isReadN   = isRead;
    isBurstN  = isBurst;
    isExtN    = isExt;
    portN     = fifoPort;
    strobeHit = 1'b0;
    pushHit   = 1'b0;
    popHit    = 1'b0;
    if (act) begin
      unique case (state)
        S_HDR: begin
          isReadN    = hdrRw;
          isBurstN   = hdrBurst;
          cmd.txLoad = 1'b1;
          if (hdrAddr <= LAST_NORM) begin
            isExtN = 1'b0;
            addrN  = EXT_AW'(hdrAddr);
            stateN = S_DATA;
            if (hdrRw) begin
              cmd.txSrc = TX_REG;
              cmd.rdIdx = EXT_AW'(hdrAddr);
            end
          end else if (hdrAddr == EXT_ESC) begin
            isExtN = 1'b1;
            stateN = S_EXTA;
          end else if (hdrAddr <= STROBE_HI) begin
            strobeHit = 1'b1;
          end else begin
            portN  = hdrAddr[0];
            stateN = S_FIFO;
            if (hdrRw) cmd.txSrc = TX_FIFO;
          end
        end
        S_EXTA: begin
          addrN      = rxByte;
          stateN     = S_DATA;
          cmd.txLoad = 1'b1;
          if (isRead) begin
            cmd.txSrc = TX_REG;
            cmd.rdExt = 1'b1;
            cmd.rdIdx = rxByte;
          end
        end
        S_DATA: begin
          cmd.txLoad = 1'b1;
          if (!isRead) begin
            cmd.wrEn  = 1'b1;
            cmd.wrExt = isExt;
            cmd.wrIdx = addr;
          end
          if (isBurst) begin
            addrN = nextAddr;
            if (isRead) begin
              cmd.txSrc = TX_REG;
              cmd.rdExt = isExt;
              cmd.rdIdx = nextAddr;
            end
          end else begin
            stateN = S_HDR;
          end
        end
        S_FIFO: begin
          if (isRead) popHit  = 1'b1;
          else        pushHit = 1'b1;
          if (!isBurst) begin
            stateN     = S_HDR;
            cmd.txLoad = 1'b1;
          end
        end
        default: stateN = S_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_HDR;
      addr       <= '0;
      isRead     <= 1'b0;
      isBurst    <= 1'b0;
      isExt      <= 1'b0;
      fifoPort   <= 1'b0;
      cmdValid   <= 1'b0;
      cmdCode    <= '0;
      fifoPush   <= 1'b0;
      fifoPop    <= 1'b0;
      fifoWrData <= '0;
    end else begin
      cmdValid <= strobeHit;
      fifoPush <= pushHit;
      fifoPop  <= popHit;
      if (strobeHit) cmdCode <= hdrAddr;
      if (pushHit)   fifoWrData <= rxByte;
      if (csIdle) begin
        state <= S_HDR;
      end else begin
        state    <= stateN;
        addr     <= addrN;
        isRead   <= isReadN;
        isBurst  <= isBurstN;
        isExt    <= isExtN;
        fifoPort <= portN;
      end
    end
  end

  assert_strobe_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdCode >= STROBE_LO && cmdCode <= STROBE_HI));

  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, fifoPush, fifoPop}));

  assert_norm_addr_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!isExt) |-> addr <= EXT_AW'(LAST_NORM));

  assert_header_after_deselect_R9: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> state == S_HDR);

  assert_blocked_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    blocked |=> !(cmdValid || fifoPush || fifoPop));
endmodule

// File: rtl/spi_hdr_regif.sv
module spi_hdr_regif
  import spi_hdr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiSi,
  output logic       spiSo,
  output logic       spiSoEn,
  input  logic       chipReady,
  input  logic [2:0] radioState,
  output logic       cmdValid,
  output logic [5:0] cmdCode,
  output logic       fifoPort,
  output logic       fifoPush,
  output logic [7:0] fifoWrData,
  output logic       fifoPop,
  input  logic [7:0] fifoRdData
);
  ctlCmd_t           cmd;
  logic              byteDone, csIdle, blocked;
  logic [BYTE_W-1:0] rxByte;

  spi_hdr_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiSi(spiSi),
    .chipReady(chipReady), .radioState(radioState), .cmd(cmd), .fifoRdData(fifoRdData),
    .spiSo(spiSo), .spiSoEn(spiSoEn), .byteDone(byteDone), .rxByte(rxByte),
    .csIdle(csIdle), .blocked(blocked)
  );

  spi_hdr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .rxByte(rxByte), .csIdle(csIdle),
    .blocked(blocked), .cmd(cmd), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .fifoPort(fifoPort), .fifoPush(fifoPush), .fifoWrData(fifoWrData), .fifoPop(fifoPop)
  );
endmodule

// File: tb/test_spi_hdr_regif.sv
module test_spi_hdr_regif;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiSi = 1'b0;
  logic spiSo, spiSoEn;
  logic chipReady = 1'b1;
  logic [2:0] radioState = 3'd0;
  logic cmdValid, fifoPort, fifoPush, fifoPop;
  logic [5:0] cmdCode;
  logic [7:0] fifoWrData, fifoRdData;

  int checks = 0, fails = 0;
  int strobeCnt = 0, pushCnt = 0, popCnt = 0;
  logic [5:0] strobeLog [32];
  logic [7:0] pushLog [8];
  logic       pushPort [8];
  logic       done = 1'b0;

  always #10 clk = ~clk;

  assign fifoRdData = 8'h3C + 8'(popCnt) * 8'h29;

  spi_hdr_regif i_spi_hdr_regif (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiSi(spiSi),
    .spiSo(spiSo), .spiSoEn(spiSoEn), .chipReady(chipReady), .radioState(radioState),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .fifoPort(fifoPort), .fifoPush(fifoPush),
    .fifoWrData(fifoWrData), .fifoPop(fifoPop), .fifoRdData(fifoRdData)
  );

  always @(posedge clk) begin
    if (cmdValid) begin strobeLog[strobeCnt % 32] <= cmdCode; strobeCnt <= strobeCnt + 1; end
    if (fifoPush) begin
      pushLog[pushCnt % 8] <= fifoWrData; pushPort[pushCnt % 8] <= fifoPort; pushCnt <= pushCnt + 1;
    end
    if (fifoPop) popCnt <= popCnt + 1;
  end

  function automatic logic [7:0] pn(input int i); return 8'(i * 37 + 11); endfunction
  function automatic logic [7:0] pe(input int i); return 8'(i * 13 + 7) ^ 8'h80; endfunction
  function automatic logic [7:0] stat(input logic rdy, input logic [2:0] st); return {~rdy, st, 4'b0}; endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csLow();
    @(negedge clk); spiCsN = 1'b0;
  endtask

  task automatic csHigh();
    spiSclk = 1'b0;
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nBits; b--) begin
      spiSclk = 1'b0; spiSi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = spiSo;
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic readNorm(input int a, output logic [7:0] v);
    logic [7:0] r;
    csLow(); xfer(8'h80 | 8'(a), r); xfer(8'h00, v); csHigh();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, v;
    int okCnt;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R9 idle output enable after reset", int'(spiSoEn), 0);
    chk("R6 no strobe after reset", strobeCnt, 0);

    // status byte for every radio state
    for (int st = 0; st < 8; st++) begin
      radioState = 3'(st);
      csLow(); xfer(8'h3D, r); csHigh();
      chk("R2 status during header", int'(r), int'(stat(1'b1, 3'(st))));
    end
    radioState = 3'd5;

    // burst write of the whole normal space, status on data bytes
    csLow(); xfer(8'h40, r);
    okCnt = 0;
    for (int i = 0; i < 47; i++) begin
      xfer(pn(i), r);
      if (r == stat(1'b1, 3'd5)) okCnt++;
    end
    csHigh();
    chk("R10 status on write data bytes", okCnt, 47);

    // burst read back
    csLow(); xfer(8'hC0, r);
    okCnt = 0;
    for (int i = 0; i < 47; i++) begin
      xfer(8'h00, r);
      if (r == pn(i)) okCnt++;
      else $display("FAIL R4 burst read addr %0h actual=%0h expected=%0h", i, r, pn(i));
    end
    csHigh();
    chk("R4 burst read matches, R1 bit order", okCnt, 47);

    // single reads each followed by a strobe header in the same selection
    strobeCnt = 0;
    okCnt = 0;
    for (int i = 0; i < 47; i++) begin
      csLow(); xfer(8'h80 | 8'(i), r); xfer(8'h00, v); xfer(8'h3D, r); csHigh();
      if (v == pn(i) && r == stat(1'b1, 3'd5)) okCnt++;
    end
    chk("R3 single read then header", okCnt, 47);
    chk("R3 strobe count after single reads", strobeCnt, 47);

    // single write then read in one selection
    csLow(); xfer(8'h05, r); xfer(8'hA5, r); xfer(8'h85, r); xfer(8'h00, v); csHigh();
    chk("R3 single write then read", int'(v), 8'hA5);

    // normal burst wrap 0x2E -> 0x00
    csLow(); xfer(8'h6D, r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); csHigh();
    readNorm(8'h2D, v); chk("R4 wrap write 2D", int'(v), 8'h11);
    readNorm(8'h2E, v); chk("R4 wrap write 2E", int'(v), 8'h22);
    readNorm(8'h00, v); chk("R4 wrap write to 00", int'(v), 8'h33);
    readNorm(8'h01, v); chk("R4 wrap leaves 01", int'(v), int'(pn(1)));

    // extended space burst write of all entries
    csLow(); xfer(8'h6F, r); xfer(8'h00, r);
    chk("R10 status on index byte", int'(r), int'(stat(1'b1, 3'd5)));
    for (int i = 0; i < 256; i++) xfer(pe(i), r);
    csHigh();
    csLow(); xfer(8'hEF, r); xfer(8'h00, r);
    okCnt = 0;
    for (int i = 0; i < 256; i++) begin
      xfer(8'h00, r);
      if (r == pe(i)) okCnt++;
    end
    csHigh();
    chk("R5 extended burst read", okCnt, 256);

    // extended read wrap FE..01
    csLow(); xfer(8'hEF, r); xfer(8'hFE, r);
    okCnt = 0;
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, r);
      if (r == pe((254 + i) % 256)) okCnt++;
    end
    csHigh();
    chk("R5 extended read wraps past FF", okCnt, 4);

    // extended write wrap and single read
    csLow(); xfer(8'h6F, r); xfer(8'hFF, r); xfer(8'h9A, r); xfer(8'h9B, r); csHigh();
    csLow(); xfer(8'hAF, r); xfer(8'h00, r); xfer(8'h00, v); csHigh();
    chk("R5 extended write wrap to 00", int'(v), 8'h9B);
    csLow(); xfer(8'hAF, r); xfer(8'hFF, r); xfer(8'h00, v); csHigh();
    chk("R5 extended single read FF", int'(v), 8'h9A);

    // strobe sweep with all direction and burst bit variants
    strobeCnt = 0;
    csLow();
    for (int c = 8'h30; c <= 8'h3D; c++) xfer(8'(c) | 8'(((c & 3)) << 6), r);
    csHigh();
    chk("R6 strobe pulse count", strobeCnt, 14);
    okCnt = 0;
    for (int c = 0; c < 14; c++) if (strobeLog[c] == 6'(8'h30 + c)) okCnt++;
    chk("R6 strobe codes in order", okCnt, 14);

    // queue writes
    pushCnt = 0;
    csLow(); xfer(8'h7F, r); xfer(8'hD1, r); xfer(8'hD2, r); xfer(8'hD3, r); csHigh();
    csLow(); xfer(8'h3E, r); xfer(8'hE4, r); xfer(8'h3D, r); csHigh();
    chk("R7 push count", pushCnt, 4);
    chk("R7 push data", int'({pushLog[0], pushLog[1], pushLog[2], pushLog[3]}), 32'hD1D2D3E4);
    chk("R7 push port", int'({pushPort[0], pushPort[1], pushPort[2], pushPort[3]}), 4'b1110);
    chk("R7 single window then header", int'(r), int'(stat(1'b1, 3'd5)));

    // queue read, one pop per sent byte
    popCnt = 0;
    csLow(); xfer(8'hFF, r);
    okCnt = 0;
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, r);
      if (r == 8'(8'h3C + 8'(i) * 8'h29)) okCnt++;
    end
    csHigh();
    chk("R7 read window data", okCnt, 3);
    chk("R7 pop count", popCnt, 3);

    // not ready at select: SO high, all ignored
    strobeCnt = 0;
    chipReady = 1'b0; radioState = 3'd2;
    csLow(); xfer(8'h07, r); xfer(8'h5E, v); xfer(8'h31, v); csHigh();
    chipReady = 1'b1;
    chk("R8 status while not ready", int'(r), int'(stat(1'b0, 3'd2)));
    readNorm(7, v);
    chk("R8 register untouched", int'(v), int'(pn(7)));
    chk("R8 no strobe while not ready", strobeCnt, 0);

    // abort mid-byte
    csLow(); xfer(8'h06, r); xferBits(8'h00, 4, r); csHigh();
    readNorm(6, v);
    chk("R9 partial byte dropped", int'(v), int'(pn(6)));
    pushCnt = 0;
    csLow(); xfer(8'h3F, r); xferBits(8'h77, 5, r); csHigh();
    chk("R9 partial queue byte dropped", pushCnt, 0);
    chk("R9 output enable released", int'(spiSoEn), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule